// File: doc/BRIEF.md
# PWM Compare Shadow-Update Controller

This block stands between a processor-side register port and a PWM timing engine. It keeps four 12-bit compare values (RA, SA, SB, RB), an output-configuration word and a 2-bit waveform mode. Each has a staging copy written by software and an active copy driven to the engine. The engine pulses an end-of-cycle strobe. The controller decides on that strobe whether the staged set moves into the active set, so that a running PWM period never sees a half-written group of values.

Three controls choose the policy. In free mode every strobe copies the staged set. Lock holds all copies until it is cleared, and the copy then waits for the next strobe. Autolock copies only when RB was the last compare value written, and it takes priority over lock. Fifty-percent mode makes the active RA and SA copies of the staged RB and SB at each transfer. The polarity and clock-select bits are plain configuration and take effect one clock after they are written.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After a synchronous reset every active value, the mode, polarity and clock-select outputs are 0. That is one-ramp mode, active-low outputs and the slow clock.
- R2: With lock and autolock both clear, a compare write (wr_sel 0=RA, 1=SA, 2=SB, 3=RB) stays off the active outputs until the next cycle_end strobe. It appears on them one clock after that strobe.
- R3: While lock (cfg_wdata bit 0) is set and autolock is clear, no strobe changes an active value. Clearing lock changes nothing by itself. The pending values transfer at the following strobe.
- R4: With autolock (cfg_wdata bit 1) set, a strobe transfers only if RB was the most recent compare write. A write to RA, SA or SB after RB cancels that condition.
- R5: With autolock and lock both set, the autolock rule applies, so a strobe after an RB write transfers.
- R6: With fifty mode (cfg_wdata bit 2) set, a transfer loads active RA from staged RB and active SA from staged SB. Once fifty mode is cleared, RA and SA transfer from their own staging copies again.
- R7: The mode field (cfg_wdata bits 4:3; 00 one-ramp, 01 two-ramp, 10 four-ramp, 11 center-aligned) is staged on a config write. It reaches act_mode only on a transfer.
- R8: Polarity (cfg_wdata bit 5, 1 = active high) and clock select (cfg_wdata bit 6, 1 = fast clock) appear on their outputs one clock after the config write, with no strobe needed.
- R9: If a compare write and a strobe fall in the same clock, the strobe transfers the value staged before that write. The new value stays pending for a later transfer.
- R10: The output-configuration word (wr_sel 4, low bits of wr_data) is staged and transferred under the same policy as the compare values.
- R11: A transfer clears the RB-last-written condition. Under autolock, a later strobe with no fresh RB write does not transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Staging write enable |
| wr_sel | input | 3 | Target: 0 RA, 1 SA, 2 SB, 3 RB, 4 output configuration |
| wr_data | input | 12 | Staging write data |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 7 | Configuration: lock, autolock, fifty, mode[1:0], polarity, clock select (bit 0 upward) |
| cycle_end | input | 1 | End-of-PWM-cycle strobe from the engine |
| act_ra | output | 12 | Active RA compare |
| act_sa | output | 12 | Active SA compare |
| act_sb | output | 12 | Active SB compare |
| act_rb | output | 12 | Active RB compare |
| act_ocfg | output | 4 | Active output-configuration word |
| act_mode | output | 2 | Active waveform mode |
| pol_high | output | 1 | 1 = outputs active high |
| clk_fast | output | 1 | 1 = fast clock input selected |

## Verification
The hardest case to reach from the ports is an autolock strobe whose RB-last condition has been cancelled by a later RA or SA write, or already used up by an earlier transfer. In both cases a staged value looks pending, yet nothing may move. The directed sequence builds this up step by step. It writes RB and then SA before a strobe and checks that nothing moved. It then writes RB alone and sees the whole set move. Last, it writes RA alone and checks that the next strobe leaves RA untouched. A second case is a write and a strobe in the same clock. A dedicated helper drives both in one cycle and then checks the old value first and the new value one strobe later.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int CMP_N  = 4;
  localparam int SEL_W  = 3;
  localparam logic [SEL_W-1:0] SEL_RA   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SA   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SB   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_RB   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_OCFG = 3'd4;

  typedef struct packed {
    logic       clk_fast;
    logic       pol_high;
    logic [1:0] mode;
    logic       fifty;
    logic       autolock;
    logic       lock;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import pwm_shadow_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  cfg_t cfg_wdata,
  output cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  p_cfg_load_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_q == $past(cfg_wdata)));
endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
  import pwm_shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             cycle_end,
  input  logic             lock,
  input  logic             autolock,
  output logic             xfer,
  output logic             rb_last
);
  logic wr_rb, wr_other_cmp;

  assign wr_rb        = wr_en && (wr_sel == SEL_RB);
  assign wr_other_cmp = wr_en && (wr_sel == SEL_RA || wr_sel == SEL_SA || wr_sel == SEL_SB);

  // autolock has priority over lock
  always_comb begin
    if (!cycle_end)    xfer = 1'b0;
    else if (autolock) xfer = rb_last;
    else               xfer = !lock;
  end

  // a write in the same clock as a transfer wins
  always_ff @(posedge clk) begin
    if (rst)               rb_last <= 1'b0;
    else if (wr_rb)        rb_last <= 1'b1;
    else if (wr_other_cmp) rb_last <= 1'b0;
    else if (xfer)         rb_last <= 1'b0;
  end

  p_rb_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    wr_rb |=> rb_last);
  p_rb_flag_cancel_r4: assert property (@(posedge clk) disable iff (rst)
    wr_other_cmp |=> !rb_last);
  p_xfer_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (xfer && !wr_en) |=> !rb_last);
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
  import pwm_shadow_pkg::*;
#(
  parameter int W   = 12,
  parameter int OCW = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [W-1:0]              wr_data,
  input  logic [1:0]                mode_stg,
  input  logic                      xfer,
  input  logic                      fifty,
  output logic [CMP_N-1:0][W-1:0]   act_cmp,
  output logic [OCW-1:0]            act_ocfg,
  output logic [1:0]                act_mode
);
  logic [CMP_N-1:0][W-1:0] stg_q;
  logic [OCW-1:0]          stg_ocfg;

  for (genvar i = 0; i < CMP_N; i++) begin : g_cmp
    localparam int SRC = (i == int'(SEL_RA)) ? int'(SEL_RB) :
                         (i == int'(SEL_SA)) ? int'(SEL_SB) : i;
    logic [W-1:0] src;
    assign src = fifty ? stg_q[SRC] : stg_q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        stg_q[i]   <= '0;
        act_cmp[i] <= '0;
      end else begin
        if (wr_en && wr_sel == SEL_W'(i)) stg_q[i] <= wr_data;
        if (xfer) act_cmp[i] <= src;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_ocfg <= '0;
      act_ocfg <= '0;
      act_mode <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_OCFG) stg_ocfg <= wr_data[OCW-1:0];
      if (xfer) begin
        act_ocfg <= stg_ocfg;
        act_mode <= mode_stg;
      end
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> ($stable(act_cmp) && $stable(act_ocfg) && $stable(act_mode)));
  p_copy_rb_r2: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (act_cmp[SEL_RB] == $past(stg_q[SEL_RB])));
  p_fifty_mirror_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer && fifty) |=> (act_cmp[SEL_RA] == act_cmp[SEL_RB] &&
                         act_cmp[SEL_SA] == act_cmp[SEL_SB]));
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int W   = 12,
  parameter int OCW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cycle_end,
  output logic [W-1:0]     act_ra,
  output logic [W-1:0]     act_sa,
  output logic [W-1:0]     act_sb,
  output logic [W-1:0]     act_rb,
  output logic [OCW-1:0]   act_ocfg,
  output logic [1:0]       act_mode,
  output logic             pol_high,
  output logic             clk_fast
);
  cfg_t                    cfg_q;
  logic                    xfer, rb_last;
  logic [CMP_N-1:0][W-1:0] act_cmp;

  shadow_cfg_regs u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_t'(cfg_wdata)),
    .cfg_q     (cfg_q)
  );

  shadow_xfer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .cycle_end (cycle_end),
    .lock      (cfg_q.lock),
    .autolock  (cfg_q.autolock),
    .xfer      (xfer),
    .rb_last   (rb_last)
  );

  shadow_reg_bank #(.W(W), .OCW(OCW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .mode_stg (cfg_q.mode),
    .xfer     (xfer),
    .fifty    (cfg_q.fifty),
    .act_cmp  (act_cmp),
    .act_ocfg (act_ocfg),
    .act_mode (act_mode)
  );

  assign act_ra   = act_cmp[SEL_RA];
  assign act_sa   = act_cmp[SEL_SA];
  assign act_sb   = act_cmp[SEL_SB];
  assign act_rb   = act_cmp[SEL_RB];
  assign pol_high = cfg_q.pol_high;
  assign clk_fast = cfg_q.clk_fast;

  p_strobe_only_r2: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(act_rb));
  p_lock_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.lock && !cfg_q.autolock) |=> $stable(act_cmp));
  p_autolock_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.autolock && !rb_last) |=> ($stable(act_cmp) && $stable(act_mode)));
endmodule

// File: tb/test_pwm_shadow_ctrl.sv
module test_pwm_shadow_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int OCW = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic           wr_en;
  logic [2:0]     wr_sel;
  logic [W-1:0]   wr_data;
  logic           cfg_we;
  logic [6:0]     cfg_wdata;
  logic           cycle_end;
  logic [W-1:0]   act_ra, act_sa, act_sb, act_rb;
  logic [OCW-1:0] act_ocfg;
  logic [1:0]     act_mode;
  logic           pol_high, clk_fast;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shadow_ctrl #(.W(W), .OCW(OCW)) i_pwm_shadow_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cycle_end(cycle_end),
    .act_ra(act_ra), .act_sa(act_sa), .act_sb(act_sb), .act_rb(act_rb),
    .act_ocfg(act_ocfg), .act_mode(act_mode), .pol_high(pol_high), .clk_fast(clk_fast)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit we, logic [2:0] sel, logic [W-1:0] d,
                      bit cwe, logic [6:0] cd, bit strobe);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d;
    cfg_we = cwe; cfg_wdata = cd; cycle_end = strobe;
    @(negedge clk);
    wr_en = 0; cfg_we = 0; cycle_end = 0;
  endtask

  task automatic wr(logic [2:0] sel, logic [W-1:0] d);
    step(1, sel, d, 0, '0, 0);
  endtask

  task automatic strobe();
    step(0, '0, '0, 0, '0, 1);
  endtask

  // bit0 lock, bit1 autolock, bit2 fifty, bits4:3 mode, bit5 pol, bit6 fast
  task automatic cfg(bit lk, bit al, bit ff, logic [1:0] md, bit pl, bit fs);
    step(0, '0, '0, 1, {fs, pl, md, ff, al, lk}, 0);
  endtask

  task automatic t_reset();
    check("R1", "act_ra", act_ra, 0);
    check("R1", "act_rb", act_rb, 0);
    check("R1", "act_mode", act_mode, 0);
    check("R1", "pol_high", pol_high, 0);
    check("R1", "clk_fast", clk_fast, 0);
    check("R1", "act_ocfg", act_ocfg, 0);
  endtask

  task automatic t_free();
    wr(3'd3, 12'h123);
    check("R2", "rb before strobe", act_rb, 0);
    wr(3'd0, 12'h0AA);
    step(0, '0, '0, 0, '0, 0);
    check("R2", "ra idle", act_ra, 0);
    strobe();
    check("R2", "rb after strobe", act_rb, 12'h123);
    check("R2", "ra after strobe", act_ra, 12'h0AA);
  endtask

  task automatic t_same_cycle();
    wr(3'd2, 12'h050);
    strobe();
    check("R9", "sb first", act_sb, 12'h050);
    step(1, 3'd2, 12'h060, 0, '0, 1);
    check("R9", "sb old value moved", act_sb, 12'h050);
    strobe();
    check("R9", "sb pending moved", act_sb, 12'h060);
  endtask

  task automatic t_lock();
    cfg(1, 0, 0, 2'b00, 0, 0);
    wr(3'd0, 12'h111);
    wr(3'd3, 12'h222);
    strobe();
    strobe();
    check("R3", "ra held", act_ra, 12'h0AA);
    check("R3", "rb held", act_rb, 12'h123);
    cfg(0, 0, 0, 2'b00, 0, 0);
    check("R3", "rb held at release", act_rb, 12'h123);
    strobe();
    check("R3", "ra after release", act_ra, 12'h111);
    check("R3", "rb after release", act_rb, 12'h222);
  endtask

  task automatic t_mode_ocfg();
    cfg(1, 0, 0, 2'b11, 0, 0);
    wr(3'd4, 12'h005);
    strobe();
    check("R7", "mode held by lock", act_mode, 0);
    check("R10", "ocfg held by lock", act_ocfg, 0);
    cfg(0, 0, 0, 2'b11, 0, 0);
    check("R7", "mode not yet", act_mode, 0);
    strobe();
    check("R7", "center-aligned", act_mode, 3);
    check("R10", "ocfg moved", act_ocfg, 5);
    cfg(0, 0, 0, 2'b01, 0, 0);
    strobe();
    check("R7", "two-ramp", act_mode, 1);
    cfg(0, 0, 0, 2'b10, 0, 0);
    strobe();
    check("R7", "four-ramp", act_mode, 2);
  endtask

  task automatic t_pol_clk();
    cfg(0, 0, 0, 2'b10, 1, 1);
    check("R8", "pol_high", pol_high, 1);
    check("R8", "clk_fast", clk_fast, 1);
    cfg(0, 0, 0, 2'b10, 0, 1);
    check("R8", "pol back low", pol_high, 0);
  endtask

  task automatic t_autolock();
    cfg(0, 1, 0, 2'b10, 0, 0);
    wr(3'd1, 12'h333);
    strobe();
    check("R4", "sa without rb", act_sa, 0);
    wr(3'd3, 12'h444);
    wr(3'd1, 12'h335);
    strobe();
    check("R4", "rb cancelled by sa", act_rb, 12'h222);
    wr(3'd3, 12'h445);
    strobe();
    check("R4", "rb moved", act_rb, 12'h445);
    check("R4", "sa moved", act_sa, 12'h335);
    wr(3'd0, 12'h777);
    strobe();
    check("R11", "ra held after transfer", act_ra, 12'h111);
  endtask

  task automatic t_override();
    cfg(1, 1, 0, 2'b10, 0, 0);
    wr(3'd3, 12'h500);
    strobe();
    check("R5", "rb under lock+autolock", act_rb, 12'h500);
    check("R5", "ra under lock+autolock", act_ra, 12'h777);
  endtask

  task automatic t_fifty();
    cfg(0, 0, 1, 2'b10, 0, 0);
    wr(3'd3, 12'h600);
    wr(3'd2, 12'h0C0);
    strobe();
    check("R6", "ra mirrors rb", act_ra, 12'h600);
    check("R6", "sa mirrors sb", act_sa, 12'h0C0);
    check("R6", "rb", act_rb, 12'h600);
    cfg(0, 0, 0, 2'b10, 0, 0);
    strobe();
    check("R6", "ra own copy", act_ra, 12'h777);
    check("R6", "sa own copy", act_sa, 12'h335);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_en = 0; wr_sel = '0; wr_data = '0;
    cfg_we = 0; cfg_wdata = '0; cycle_end = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_free();
    t_same_cycle();
    t_lock();
    t_mode_ocfg();
    t_pol_clk();
    t_autolock();
    t_override();
    t_fifty();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule